// File: doc/BRIEF.md
# Per-Processor Interrupt Level Combiner

This block sits beside one processor and turns several interrupt causes into fifteen level-request lines for it. A 32-bit pending word holds three kinds of local cause: software requests in the upper half of the word, a local timer bit, and a copy of a level-15 request that is broadcast to every processor. Each cycle the block merges these causes with a 16-bit hard level vector. That vector comes from a separate system router that maps sources to levels and picks the target processor.

Software programs the pending word through a small word-indexed bus. One index returns the word. One index clears selected bits when written with ones. One index sets selected bits when written with ones. A software bit at position k, with k from 17 to 31, requests level k-16. The timer bit and the broadcast bit reach the outputs with no masking. The broadcast bit can also be cleared locally, so a processor can acknowledge it while the others still see it. Every output line comes from its own flop. A line changes only when the level computed for it changes.

Top module: `cpu_irq_combiner`

## Requirements
- R1: Reset sets the pending word and all sixteen `lvl_req` lines to 0.
- R2: A write to word index 2 sets the pending bits 31..17 whose data bit is 1. It leaves bits 16..0 unchanged, and bits 16 and 13..0 of the pending word always read 0.
- R3: A write to word index 1 clears the pending bits 31..17 and bit 15 whose data bit is 1. It does not change bit 14.
- R4: A pending software bit k (17 to 31) drives level line k-16.
- R5: Pending bit 14 follows `timer_in` one clock later, and that bit drives level line 14 with no masking. Clear writes do not affect it.
- R6: A rising edge on `bcast15_in` sets pending bit 15 and a falling edge clears it. A rising edge in the same cycle as a local clear of bit 15 leaves the bit set. Bit 15 drives level line 15 unmasked.
- R7: Each `hard_lvl` bit n (1 to 15) drives level line n. Hard levels never appear in the pending word.
- R8: `lvl_req[0]` is never asserted.
- R9: Each `lvl_req` line is registered. It shows the merged level one clock after the cause appears and holds steady while the cause persists, so it has one rising edge per cause.
- R10: With `bus_addr` = 0, `bus_rdata` returns the pending word in the same cycle. Indices 1, 2 and 3 read 0, and a write to index 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the word at `bus_addr` |
| bus_addr | input | 2 | Word index: 0 pending, 1 clear, 2 set, 3 unused |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| timer_in | input | 1 | Local timer request, level sensitive |
| bcast15_in | input | 1 | Broadcast level-15 request |
| hard_lvl | input | 16 | Hard level vector from the system router |
| lvl_req | output | 16 | Registered level-request lines to the processor |

## Verification
The bound checker checks on every cycle the properties that hold at all times:
- line 0 stays low;
- set and clear writes take effect on the next cycle;
- bits that are never stored stay at zero;
- the timer bit tracks its input;
- a rising broadcast edge sets bit 15;
- hard and software levels appear on the lines one cycle later.

Only the bench scenarios can show the rest:
- that ignored bits in the set, clear and unused words leave the pending word alone;
- that a local clear of bit 15 loses to a rising broadcast edge in the same cycle but works otherwise;
- that a falling broadcast edge clears bit 15;
- the read-back values of the other word indices;
- the rising-edge count of a line while its cause is held.

// File: rtl/cic_pkg.sv
package cic_pkg;
   typedef enum logic [1:0] {
      CIC_W_PEND = 2'd0,
      CIC_W_CLR  = 2'd1,
      CIC_W_SET  = 2'd2,
      CIC_W_NONE = 2'd3
   } cic_word_e;
endpackage

// File: rtl/cic_pending_reg.sv
module cic_pending_reg #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned SOFT_LO   = 17,
   parameter int unsigned TIMER_BIT = 14,
   parameter int unsigned BCAST_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_req,
   input  logic [DATA_W-1:0] clr_req,
   input  logic              timer_in,
   input  logic              bcast_in,
   output logic [DATA_W-1:0] pend_q
);
   localparam logic [DATA_W-1:0] SOFT_MASK =
      {{(DATA_W-SOFT_LO){1'b1}}, {SOFT_LO{1'b0}}};

   logic              bcast_q;
   logic              bcast_rise;
   logic              bcast_fall;
   logic              b15_d;
   logic [DATA_W-1:0] soft_d;
   logic [DATA_W-1:0] pend_d;

   assign bcast_rise = bcast_in & ~bcast_q;
   assign bcast_fall = ~bcast_in & bcast_q;

   // set dominates clear on a soft bit
   assign soft_d = (pend_q & SOFT_MASK & ~clr_req) | (set_req & SOFT_MASK);

   always_comb begin
      if (bcast_rise)            b15_d = 1'b1;
      else if (bcast_fall)       b15_d = 1'b0;
      else if (clr_req[BCAST_BIT]) b15_d = 1'b0;
      else                       b15_d = pend_q[BCAST_BIT];
   end

   always_comb begin
      pend_d            = soft_d;
      pend_d[BCAST_BIT] = b15_d;
      pend_d[TIMER_BIT] = timer_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         bcast_q <= 1'b0;
      end else begin
         pend_q  <= pend_d;
         bcast_q <= bcast_in;
      end
   end
endmodule

// File: rtl/cic_level_merge.sv
module cic_level_merge #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LVL_N     = 16,
   parameter int unsigned TIMER_BIT = 14,
   parameter int unsigned BCAST_BIT = 15
) (
   input  logic [DATA_W-1:0] pend,
   input  logic [LVL_N-1:0]  hard_lvl,
   output logic [LVL_N-1:0]  lvl_vec
);
   localparam logic [LVL_N-1:0] LOCAL_MASK =
      LVL_N'((64'd1 << TIMER_BIT) | (64'd1 << BCAST_BIT));
   localparam logic [LVL_N-1:0] NO_ZERO = ~LVL_N'(1);

   logic [LVL_N-1:0] soft_lvl;
   logic [LVL_N-1:0] raw_lvl;

   assign soft_lvl = pend[DATA_W-1 -: LVL_N];
   assign raw_lvl  = hard_lvl | (pend[LVL_N-1:0] & LOCAL_MASK) | soft_lvl;
   assign lvl_vec  = raw_lvl & NO_ZERO;
endmodule

// File: rtl/cic_line_drive.sv
module cic_line_drive #(
   parameter int unsigned LVL_N = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_N-1:0] lvl_vec,
   output logic [LVL_N-1:0] lvl_req
);
   for (genvar g = 0; g < LVL_N; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                   lvl_req[g] <= 1'b0;
         else if (lvl_req[g] != lvl_vec[g]) lvl_req[g] <= lvl_vec[g];
      end
   end
endmodule

// File: rtl/cpu_irq_combiner.sv
module cpu_irq_combiner #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LVL_N     = 16,
   parameter int unsigned TIMER_BIT = 14,
   parameter int unsigned BCAST_BIT = 15,
   parameter int unsigned ADDR_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              timer_in,
   input  logic              bcast15_in,
   input  logic [LVL_N-1:0]  hard_lvl,
   output logic [LVL_N-1:0]  lvl_req
);
   import cic_pkg::*;

   localparam int unsigned SOFT_LO = LVL_N + 1;

   if (DATA_W != 2 * LVL_N) begin : g_bad_width
      $error("DATA_W must be twice LVL_N");
   end
   if (TIMER_BIT >= LVL_N || BCAST_BIT >= LVL_N || TIMER_BIT == BCAST_BIT) begin : g_bad_bits
      $error("timer and broadcast bits must be distinct levels");
   end
   if (ADDR_W != 2) begin : g_bad_addr
      $error("ADDR_W must be 2");
   end

   cic_word_e         word;
   logic [DATA_W-1:0] set_req;
   logic [DATA_W-1:0] clr_req;
   logic [DATA_W-1:0] pend_q;
   logic [LVL_N-1:0]  lvl_vec;

   assign word    = cic_word_e'(bus_addr);
   assign set_req = (bus_wr && word == CIC_W_SET) ? bus_wdata : '0;
   assign clr_req = (bus_wr && word == CIC_W_CLR) ? bus_wdata : '0;
   assign bus_rdata = (word == CIC_W_PEND) ? pend_q : '0;

   cic_pending_reg #(
      .DATA_W(DATA_W), .SOFT_LO(SOFT_LO),
      .TIMER_BIT(TIMER_BIT), .BCAST_BIT(BCAST_BIT)
   ) u_pend (
      .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
      .timer_in(timer_in), .bcast_in(bcast15_in), .pend_q(pend_q)
   );

   cic_level_merge #(
      .DATA_W(DATA_W), .LVL_N(LVL_N),
      .TIMER_BIT(TIMER_BIT), .BCAST_BIT(BCAST_BIT)
   ) u_merge (
      .pend(pend_q), .hard_lvl(hard_lvl), .lvl_vec(lvl_vec)
   );

   cic_line_drive #(.LVL_N(LVL_N)) u_lines (
      .clk(clk), .rst_n(rst_n), .lvl_vec(lvl_vec), .lvl_req(lvl_req)
   );
endmodule

// File: rtl/cic_irq_chk.sv
module cic_irq_chk #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned LVL_N     = 16,
   parameter int unsigned TIMER_BIT = 14,
   parameter int unsigned BCAST_BIT = 15,
   parameter int unsigned ADDR_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              timer_in,
   input logic              bcast15_in,
   input logic [LVL_N-1:0]  hard_lvl,
   input logic [DATA_W-1:0] pend,
   input logic [LVL_N-1:0]  lvl_req
);
   localparam logic [DATA_W-1:0] SOFT_MASK =
      {{(DATA_W-LVL_N-1){1'b1}}, {(LVL_N+1){1'b0}}};
   localparam logic [LVL_N-1:0] HI = ~LVL_N'(1);

   logic [1:0] cyc;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cyc <= 2'd0;
      else if (cyc != 2'd3) cyc <= cyc + 2'd1;
   end

   // R8
   line0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lvl_req[0]);

   // R2
   soft_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(2)) |=>
      ((pend & $past(bus_wdata) & SOFT_MASK) == ($past(bus_wdata) & SOFT_MASK)));

   // R3
   soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(1)) |=>
      ((pend & $past(bus_wdata) & SOFT_MASK) == '0));

   // R2
   unused_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[TIMER_BIT-1:0] == '0) && !pend[LVL_N]);

   // R5
   timer_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0) |-> (pend[TIMER_BIT] == $past(timer_in)));

   // R6
   bcast_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bcast15_in) |=> pend[BCAST_BIT]);

   // R7
   hard_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0) |-> ((lvl_req & $past(hard_lvl) & HI) == ($past(hard_lvl) & HI)));

   // R4
   soft_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc != 2'd0) |->
      ((lvl_req & $past(pend[DATA_W-1 -: LVL_N]) & HI) == ($past(pend[DATA_W-1 -: LVL_N]) & HI)));
endmodule

bind cpu_irq_combiner cic_irq_chk #(
   .DATA_W(DATA_W), .LVL_N(LVL_N), .TIMER_BIT(TIMER_BIT),
   .BCAST_BIT(BCAST_BIT), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .timer_in(timer_in), .bcast15_in(bcast15_in),
   .hard_lvl(hard_lvl), .pend(pend_q), .lvl_req(lvl_req)
);

// File: tb/tb_cpu_irq_combiner.sv
module tb_cpu_irq_combiner;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        timer_in = 1'b0;
   logic        bcast15_in = 1'b0;
   logic [15:0] hard_lvl = '0;
   logic [15:0] lvl_req;

   int total = 0;
   int bad = 0;
   int rise3 = 0;
   logic prev3 = 1'b0;

   always #5 clk = ~clk;

   cpu_irq_combiner dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .timer_in(timer_in),
      .bcast15_in(bcast15_in), .hard_lvl(hard_lvl), .lvl_req(lvl_req)
   );

   always @(negedge clk) begin
      if (lvl_req[3] && !prev3) rise3++;
      prev3 = lvl_req[3];
   end

   typedef struct packed {
      logic        wr;
      logic [1:0]  addr;
      logic [31:0] wdata;
      logic        tmr;
      logic        bc;
      logic [15:0] hard;
      logic [31:0] exp_rd;
      logic [15:0] exp_lvl;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VECS [NV] = '{
      '{1'b1, 2'd2, 32'h0002_0000, 1'b0, 1'b0, 16'h0000, 32'h0002_0000, 16'h0002}, // R2 R4 lvl1
      '{1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0, 16'h0000, 32'hFFFE_0000, 16'hFFFE}, // R2 R4 all soft
      '{1'b1, 2'd1, 32'hFFFF_FFFF, 1'b0, 1'b0, 16'h0000, 32'h0000_0000, 16'h0000}, // R3
      '{1'b0, 2'd0, 32'h0000_0000, 1'b1, 1'b0, 16'h0000, 32'h0000_4000, 16'h4000}, // R5
      '{1'b0, 2'd0, 32'h0000_0000, 1'b0, 1'b0, 16'h0025, 32'h0000_0000, 16'h0024}, // R7 R8
      '{1'b0, 2'd0, 32'h0000_0000, 1'b0, 1'b1, 16'h0000, 32'h0000_8000, 16'h8000}, // R6 rise
      '{1'b1, 2'd1, 32'h0000_8000, 1'b0, 1'b1, 16'h0000, 32'h0000_0000, 16'h0000}, // R6 local clear
      '{1'b1, 2'd2, 32'h0001_FFFF, 1'b0, 1'b1, 16'h0000, 32'h0000_0000, 16'h0000}, // R2 ignored bits
      '{1'b0, 2'd0, 32'h0000_0000, 1'b0, 1'b0, 16'h0000, 32'h0000_0000, 16'h0000}, // R6 fall
      '{1'b1, 2'd2, 32'h8000_4000, 1'b0, 1'b0, 16'h0000, 32'h8000_0000, 16'h8000}, // R2 R4 lvl15
      '{1'b1, 2'd3, 32'hFFFF_FFFF, 1'b0, 1'b0, 16'h0000, 32'h8000_0000, 16'h8000}, // R10 unused word
      '{1'b1, 2'd1, 32'h0001_7FFF, 1'b0, 1'b0, 16'h0000, 32'h8000_0000, 16'h8000}  // R3 ignored bits
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic step(input logic wr, input logic [1:0] addr, input logic [31:0] wd,
                       input logic tmr, input logic bc, input logic [15:0] hard);
      @(negedge clk);
      bus_wr = wr; bus_addr = addr; bus_wdata = wd;
      timer_in = tmr; bcast15_in = bc; hard_lvl = hard;
      @(negedge clk);
      bus_wr = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
      @(negedge clk);
   endtask

   task automatic summary;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=finish");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state while held
      chk("R1 rdata in reset", bus_rdata, 32'h0);
      chk("R1 lvl in reset", {16'h0, lvl_req}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 rdata after reset", bus_rdata, 32'h0);
      chk("R1 lvl after reset", {16'h0, lvl_req}, 32'h0);

      for (int i = 0; i < NV; i++) begin
         step(VECS[i].wr, VECS[i].addr, VECS[i].wdata, VECS[i].tmr, VECS[i].bc, VECS[i].hard);
         chk($sformatf("vec%0d pending", i), bus_rdata, VECS[i].exp_rd);
         chk($sformatf("vec%0d levels", i), {16'h0, lvl_req}, {16'h0, VECS[i].exp_lvl});
      end

      // R6 rising broadcast beats local clear in same cycle
      step(1'b1, 2'd1, 32'h0000_8000, 1'b0, 1'b1, 16'h0);
      chk("R6 rise wins over clear", bus_rdata, 32'h8000_8000);
      chk("R6 lvl15", {16'h0, lvl_req}, 32'h0000_8000);
      // R6 falling edge clears
      step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 16'h0);
      chk("R6 fall clears", bus_rdata, 32'h8000_0000);

      // R5 timer bit survives a full clear write
      step(1'b1, 2'd1, 32'hFFFF_FFFF, 1'b1, 1'b0, 16'h0);
      chk("R5 timer kept", bus_rdata, 32'h0000_4000);
      chk("R5 lvl14", {16'h0, lvl_req}, 32'h0000_4000);

      // R10 other indices read zero
      bus_addr = 2'd1; #1;
      chk("R10 read idx1", bus_rdata, 32'h0);
      bus_addr = 2'd2; #1;
      chk("R10 read idx2", bus_rdata, 32'h0);
      bus_addr = 2'd3; #1;
      chk("R10 read idx3", bus_rdata, 32'h0);
      bus_addr = 2'd0; #1;
      chk("R10 read idx0", bus_rdata, 32'h0000_4000);

      step(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 16'h0);
      chk("R5 timer low clears", {16'h0, lvl_req}, 32'h0);

      // R9 one-cycle latency and one rising edge per held cause
      rise3 = 0;
      @(negedge clk);
      hard_lvl = 16'h0008;
      #1;
      chk("R9 not before edge", {31'h0, lvl_req[3]}, 32'h0);
      @(negedge clk);
      chk("R9 after one edge", {16'h0, lvl_req}, 32'h0000_0008);
      repeat (5) @(negedge clk);
      chk("R9 held line", {16'h0, lvl_req}, 32'h0000_0008);
      chk("R9 single rising edge", rise3, 32'd1);
      hard_lvl = 16'h0;
      @(negedge clk);
      chk("R9 drop after one edge", {16'h0, lvl_req}, 32'h0);
      // R7 hard levels never stored
      chk("R7 hard not in pending", bus_rdata, 32'h0);

      // R1 reset mid-operation
      step(1'b1, 2'd2, 32'hFFFE_0000, 1'b0, 1'b0, 16'h0);
      chk("R4 all soft lines", {16'h0, lvl_req}, 32'h0000_FFFE);
      rst_n = 1'b0;
      #1;
      chk("R1 async clear pending", bus_rdata, 32'h0);
      chk("R1 async clear lines", {16'h0, lvl_req}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8 line0 low", {31'h0, lvl_req[0]}, 32'h0);

      summary();
   end
endmodule